// File: doc/BRIEF.md
# Four-Channel Latched-Update Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from one clock. Software programs it through a 32-bit register port that takes one cycle per access. Each channel has its own free-running counter, and its pin shows a trailing-edge mark-space waveform: the pin is active from the start of each period until the counter reaches the duty value. A control bit per channel inverts the pin.

Writes never reach the waveform directly. Period and duty go into holding registers. A channel copies them into its working set only when its own period ends, so a period in progress is never cut short or stretched. Channel enables are held back in the same way. They apply to all channels on one clock edge when software sets the update bit. Channels that start together with equal periods therefore run in phase. Disabling a channel forces its pin to its idle level on the edge where the update is applied. The period in progress is not finished.

Top module: `mspwm_top`

## Requirements
- R1: After reset every channel control word reads 0x101, which is mode 1 (bits 2:0) with the FIFO-pop mask (bit 8) set. Global control, range, phase and duty read 0 and all outputs are low. Register offsets are: global control at 0x00, and for channel n, control at 0x14+16n, range at 0x18+16n, phase at 0x1C+16n and duty at 0x20+16n. Reads return the values last written to the holding registers.
- R2: In global control, bits 3:0 are the channel enables and bit 31 is the update request. A write with bit 31 set makes the enables take effect one clock later. Bit 31 reads 1 during that pending cycle and then clears itself.
- R3: An enabled channel's counter runs from 0 up to its working range value inclusive, so one period lasts range+1 clocks. A newly enabled channel starts at count 0.
- R4: In mode 1 the uninverted output is high while the counter is below the working duty value. A duty of range+1 or more gives a constantly high output.
- R5: Channel control bit 3 inverts the channel's output.
- R6: A new range or duty written during a period takes effect only at the start of that channel's next period.
- R7: Channels enabled by the same update, with equal range, start on the same clock and stay in phase.
- R8: With range and duty both 0, an enabled channel stays constantly at its inactive level: low when not inverted, high when inverted.
- R9: A channel disabled by an update goes to its idle level (0, or 1 when inverted) on the clock that applies the update, without finishing its period.
- R10: Any mode value other than 1 gives a constant inactive output. The phase register is stored and read back but does not affect the output.
- R11: Writing the enable bits without bit 31 leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the register port and the counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe; the write is captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr, available in the same cycle |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
A stale working range or duty shows on the pin in the very next period as a wrong number of high clocks, or as a period of the wrong length. The bench therefore compares every sample against the count-based expectation. An update that is applied too early or too late moves the enable edge by one clock relative to the write, which shows as a mismatch in the first sample after the update or in the readback of bit 31. Wrong idle or inversion logic shows at once as a pin at the wrong level while the channel is disabled or held at zero duty.

// File: rtl/mspwm_pkg.sv
package mspwm_pkg;
    // Mode field encodings
    localparam logic [2:0] MODE_OFF  = 3'd0;
    localparam logic [2:0] MODE_TEMS = 3'd1;

    // Address layout (byte offsets)
    localparam int GLB_OFF   = 'h00;
    localparam int CH_BASE   = 'h14;
    localparam int CH_STRIDE = 'h10;

    // Word index of each channel register inside its group
    localparam int SUB_CTRL  = 0;
    localparam int SUB_RANGE = 1;
    localparam int SUB_PHASE = 2;
    localparam int SUB_DUTY  = 3;

    // Control word bit positions
    localparam int CTRL_INV_BIT = 3;
    localparam int CTRL_POP_BIT = 8;
endpackage

// File: rtl/mspwm_regs.sv
module mspwm_regs
    import mspwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_we,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [NCH-1:0]           en_act_o,
    output logic [NCH-1:0][DW-1:0]   rng_o,
    output logic [NCH-1:0][DW-1:0]   dut_o,
    output logic [NCH-1:0][2:0]      mode_o,
    output logic [NCH-1:0]           inv_o
);
    localparam int UPD_BIT = DW - 1;

    typedef struct packed {
        logic [NCH-1:0]          en_hold;
        logic                    upd;
        logic [NCH-1:0]          en_act;
        logic [NCH-1:0][2:0]     mode;
        logic [NCH-1:0]          inv;
        logic [NCH-1:0]          popm;
        logic [NCH-1:0][DW-1:0]  rng;
        logic [NCH-1:0][DW-1:0]  ph;
        logic [NCH-1:0][DW-1:0]  dut;
    } regs_t;

    regs_t s_d, s_q;

    function automatic logic [AW-1:0] reg_addr(int c, int sub);
        return AW'(CH_BASE + c * CH_STRIDE + sub * 4);
    endfunction

    function automatic regs_t reset_val();
        regs_t r;
        r = '0;
        for (int c = 0; c < NCH; c++) begin
            r.mode[c] = MODE_TEMS;
            r.popm[c] = 1'b1;
        end
        return r;
    endfunction

    logic glob_hit;
    assign glob_hit = (bus_addr == AW'(GLB_OFF));

    always_comb begin
        s_d = s_q;
        // pending update is applied one cycle after it was requested
        if (s_q.upd) begin
            s_d.en_act = s_q.en_hold;
            s_d.upd    = 1'b0;
        end
        if (bus_we) begin
            if (glob_hit) begin
                s_d.en_hold = bus_wdata[NCH-1:0];
                if (bus_wdata[UPD_BIT]) s_d.upd = 1'b1;
            end
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == reg_addr(c, SUB_CTRL)) begin
                    s_d.mode[c] = bus_wdata[2:0];
                    s_d.inv[c]  = bus_wdata[CTRL_INV_BIT];
                    s_d.popm[c] = bus_wdata[CTRL_POP_BIT];
                end
                if (bus_addr == reg_addr(c, SUB_RANGE)) s_d.rng[c] = bus_wdata;
                if (bus_addr == reg_addr(c, SUB_PHASE)) s_d.ph[c]  = bus_wdata;
                if (bus_addr == reg_addr(c, SUB_DUTY))  s_d.dut[c] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_val();
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (glob_hit) begin
            bus_rdata[NCH-1:0] = s_q.en_hold;
            bus_rdata[UPD_BIT] = s_q.upd;
        end
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == reg_addr(c, SUB_CTRL)) begin
                bus_rdata[2:0]          = s_q.mode[c];
                bus_rdata[CTRL_INV_BIT] = s_q.inv[c];
                bus_rdata[CTRL_POP_BIT] = s_q.popm[c];
            end
            if (bus_addr == reg_addr(c, SUB_RANGE)) bus_rdata = s_q.rng[c];
            if (bus_addr == reg_addr(c, SUB_PHASE)) bus_rdata = s_q.ph[c];
            if (bus_addr == reg_addr(c, SUB_DUTY))  bus_rdata = s_q.dut[c];
        end
    end

    assign en_act_o = s_q.en_act;
    assign rng_o    = s_q.rng;
    assign dut_o    = s_q.dut;
    assign mode_o   = s_q.mode;
    assign inv_o    = s_q.inv;

    // R2: the request bit drops after one cycle unless it is written again
    assert_upd_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.upd && !(bus_we && glob_hit && bus_wdata[UPD_BIT])) |=> !s_q.upd);

    // R2: the enables that were held are what become active
    assert_en_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.upd |=> (s_q.en_act == $past(s_q.en_hold)));

    // R11: without a pending update the active enables do not move
    assert_en_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.upd |=> $stable(s_q.en_act));
endmodule

// File: rtl/mspwm_chan.sv
module mspwm_chan
    import mspwm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [DW-1:0] rng_hold_i,
    input  logic [DW-1:0] dut_hold_i,
    input  logic [2:0]    mode_i,
    input  logic          inv_i,
    output logic          out_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] rng;
        logic [DW-1:0] dut;
    } chan_t;

    chan_t s_d, s_q;
    logic  wrap;

    assign wrap = (s_q.cnt >= s_q.rng);

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            // idle: keep the working set primed so enabling starts cleanly
            s_d.cnt = '0;
            s_d.rng = rng_hold_i;
            s_d.dut = dut_hold_i;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.rng = rng_hold_i;
            s_d.dut = dut_hold_i;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic raw;
    assign raw   = en_i && (mode_i == MODE_TEMS) && (s_q.cnt < s_q.dut);
    assign out_o = raw ^ inv_i;

    // R3: the counter never passes the working range
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (s_q.cnt <= s_q.rng));

    // R6: the working range and duty change only at a period boundary
    assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> ($stable(s_q.rng) && $stable(s_q.dut)));

    // R3: a disabled channel restarts from zero
    assert_off_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/mspwm_top.sv
module mspwm_top
    import mspwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]         en_act;
    logic [NCH-1:0][DW-1:0] rng_hold;
    logic [NCH-1:0][DW-1:0] dut_hold;
    logic [NCH-1:0][2:0]    mode;
    logic [NCH-1:0]         inv;

    mspwm_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_act_o  (en_act),
        .rng_o     (rng_hold),
        .dut_o     (dut_hold),
        .mode_o    (mode),
        .inv_o     (inv)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mspwm_chan #(.DW(DW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en_act[c]),
            .rng_hold_i (rng_hold[c]),
            .dut_hold_i (dut_hold[c]),
            .mode_i     (mode[c]),
            .inv_i      (inv[c]),
            .out_o      (pwm_out[c])
        );

        // R9: a disabled channel sits at its polarity-dependent idle level
        assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !en_act[c] |-> (pwm_out[c] == inv[c]));

        // R10: only mode 1 can drive the active level
        assert_mode_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[c] != MODE_TEMS) |-> (pwm_out[c] == inv[c]));
    end
endmodule

// File: tb/tb_mspwm_top.sv
module tb_mspwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    mspwm_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] a_ctl(int c); return 8'(8'h14 + 16 * c); endfunction
    function automatic logic [7:0] a_rng(int c); return 8'(8'h18 + 16 * c); endfunction
    function automatic logic [7:0] a_ph (int c); return 8'(8'h1C + 16 * c); endfunction
    function automatic logic [7:0] a_dut(int c); return 8'(8'h20 + 16 * c); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // samples n clocks; the expected count at the first sample is s
    task automatic run_pat(int ch, int r, int d, bit inv, int s, int n, string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            logic e;
            e = ((((s + i) % (r + 1)) < d) ? 1'b1 : 1'b0) ^ inv;
            if (pwm_out[ch] !== e) bad++;
            @(negedge clk);
        end
        check(req, 32'(bad), 32'd0);
    endtask

    task automatic all_off();
        bus_wr(8'h00, 32'h8000_0000);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 outputs after reset", {28'd0, pwm_out}, 32'd0);
        for (int c = 0; c < 4; c++) begin
            bus_rd(a_ctl(c), v); check("R1 ctrl reset", v, 32'h101);
            bus_rd(a_rng(c), v); check("R1 range reset", v, 32'h0);
        end
        bus_rd(8'h00, v); check("R1 global reset", v, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        bus_wr(a_rng(3), 32'hDEAD_0007);
        bus_wr(a_ph(3), 32'h0000_0055);
        bus_wr(a_dut(3), 32'h1234_5678);
        bus_wr(a_ctl(3), 32'h109);
        bus_rd(a_rng(3), v); check("R1 range readback", v, 32'hDEAD_0007);
        bus_rd(a_ph(3), v);  check("R10 phase readback", v, 32'h55);
        bus_rd(a_dut(3), v); check("R1 duty readback", v, 32'h1234_5678);
        bus_rd(a_ctl(3), v); check("R1 ctrl readback", v, 32'h109);
        bus_wr(a_ctl(3), 32'h101);
    endtask

    task automatic t_no_update();
        logic [31:0] v;
        bus_wr(a_rng(1), 4);
        bus_wr(a_dut(1), 2);
        bus_wr(8'h00, 32'h0000_0002);
        bus_rd(8'h00, v); check("R11 enables held", v, 32'h2);
        run_pat(1, 4, 0, 0, 0, 8, "R11 no output without update");
    endtask

    task automatic t_update();
        logic [31:0] v;
        bus_wr(8'h00, 32'h8000_0002);
        bus_rd(8'h00, v); check("R2 update pending readback", v, 32'h8000_0002);
        @(negedge clk);
        bus_rd(8'h00, v); check("R2 update self clears", v, 32'h2);
        run_pat(1, 4, 2, 0, 0, 15, "R3 R4 period and duty ch1");
        all_off();
    endtask

    task automatic t_full_duty();
        bus_wr(a_rng(2), 3);
        bus_wr(a_dut(2), 4);
        bus_wr(8'h00, 32'h8000_0004);
        @(negedge clk);
        run_pat(2, 3, 4, 0, 0, 8, "R4 duty range+1 is 100%");
        all_off();
        bus_wr(a_dut(2), 3);
        bus_wr(8'h00, 32'h8000_0004);
        @(negedge clk);
        run_pat(2, 3, 3, 0, 0, 8, "R4 duty equal to range");
        all_off();
    endtask

    task automatic t_polarity();
        bus_wr(a_ctl(2), 32'h109);
        bus_wr(a_dut(2), 1);
        bus_wr(8'h00, 32'h8000_0004);
        @(negedge clk);
        run_pat(2, 3, 1, 1, 0, 8, "R5 inverted waveform");
        all_off();
        bus_wr(a_ctl(2), 32'h101);
    endtask

    task automatic t_zero();
        bus_wr(a_rng(0), 0);
        bus_wr(a_dut(0), 0);
        bus_wr(8'h00, 32'h8000_0001);
        @(negedge clk);
        run_pat(0, 0, 0, 0, 0, 6, "R8 zero range and duty low");
        bus_wr(a_ctl(0), 32'h109);
        @(negedge clk);
        run_pat(0, 0, 0, 1, 0, 6, "R8 zero range and duty inverted high");
        all_off();
        bus_wr(a_ctl(0), 32'h101);
    endtask

    task automatic t_phase_sync();
        int bad = 0;
        bus_wr(a_rng(0), 5); bus_wr(a_dut(0), 2);
        bus_wr(a_rng(3), 5); bus_wr(a_dut(3), 2);
        bus_wr(8'h00, 32'h8000_0009);
        @(negedge clk);
        for (int i = 0; i < 18; i++) begin
            logic e;
            e = ((i % 6) < 2);
            if (pwm_out[0] !== e || pwm_out[3] !== e) bad++;
            @(negedge clk);
        end
        check("R7 equal periods in phase", 32'(bad), 32'd0);
        all_off();
    endtask

    task automatic t_latch();
        bus_wr(a_rng(0), 9);
        bus_wr(a_dut(0), 3);
        bus_wr(8'h00, 32'h8000_0001);
        @(negedge clk);
        bus_wr(a_dut(0), 7);
        run_pat(0, 9, 3, 0, 2, 8, "R6 old duty kept to period end");
        run_pat(0, 9, 7, 0, 0, 10, "R6 new duty in next period");
        all_off();
    endtask

    task automatic t_disable();
        bus_wr(a_rng(0), 7);
        bus_wr(a_dut(0), 8);
        bus_wr(8'h00, 32'h8000_0001);
        @(negedge clk);
        @(negedge clk); @(negedge clk);
        bus_wr(8'h00, 32'h8000_0000);
        check("R9 still running while pending", {31'd0, pwm_out[0]}, 32'd1);
        @(negedge clk);
        check("R9 disable immediate low", {31'd0, pwm_out[0]}, 32'd0);
        bus_wr(a_ctl(0), 32'h109);
        bus_wr(8'h00, 32'h8000_0001);
        @(negedge clk); @(negedge clk);
        check("R5 inverted full duty low", {31'd0, pwm_out[0]}, 32'd0);
        bus_wr(8'h00, 32'h8000_0000);
        @(negedge clk);
        check("R9 disable immediate inverted high", {31'd0, pwm_out[0]}, 32'd1);
        bus_wr(a_ctl(0), 32'h101);
    endtask

    task automatic t_mode();
        bus_wr(a_ctl(1), 32'h102);
        bus_wr(a_rng(1), 3);
        bus_wr(a_dut(1), 2);
        bus_wr(8'h00, 32'h8000_0002);
        @(negedge clk);
        run_pat(1, 3, 0, 0, 0, 8, "R10 other mode constant inactive");
        all_off();
        bus_wr(a_ctl(1), 32'h101);
        bus_wr(a_ph(1), 2);
        bus_wr(8'h00, 32'h8000_0002);
        @(negedge clk);
        run_pat(1, 3, 2, 0, 0, 8, "R10 phase has no effect");
        all_off();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_no_update();
        t_update();
        t_full_duty();
        t_polarity();
        t_zero();
        t_phase_sync();
        t_latch();
        t_disable();
        t_mode();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule